// File: doc/BRIEF.md
# Cable PHY Base Register Page

This block is the base page of the byte-wide register bank in a serial-bus cable PHY. A link-layer controller reads and writes it through a 3-bit address, an 8-bit write port with a write strobe, and a combinational read port. The page holds three kinds of field:

- node status: the physical ID, the root flag and the cable-power indication;
- controls: root holdoff, the bus-reset request and the arbitration gap count;
- fixed capability bytes.

Other parts of the PHY report events to the block on dedicated pulse inputs: a bus reset, a root decision from tree identification, self-ID completion with the assigned ID, and a gap count carried by a configuration packet. The active-low `rst_n` is the hardware reset.

Each field follows its own reset rules. The root flag and the reset request clear on every bus reset. Root holdoff clears only on a hardware reset. The gap count falls back to its default only when two bus resets arrive with no gap update between them. When self-ID completes, the ID becomes valid and the block raises a one-cycle strobe. That strobe tells the link side to push register 0 out as an unsolicited status transfer.

Top module: `phy_base_regs`

## Requirements
- R1: After a hardware reset, address 0 reads 00h apart from the cable-power bit, address 1 reads 3Fh and `id_valid` is 0.
- R2: Bit 0 of each byte is its most significant bit (`rdata[7]`). Address 0 is {phy_id[5:0], root, cable_power}. Address 1 is {root_holdoff, reset_request, gap[5:0]}.
- R3: Address 2 reads E3h (extended field 111b, bit 3 zero, port count 3). Address 3 reads E0h (speed field 111b, bit 3 zero, delay code 0; the delay code stands for 144 + 20 × code ns). Addresses 4 to 7 read 00h. Writes to addresses 0, 2, 3 and 4 to 7 leave every readable byte unchanged.
- R4: A bus reset clears the root bit. A `tree_root` pulse with no bus reset in the same cycle sets it.
- R5: Root holdoff is written through bit 0 of address 1. It is cleared only by a hardware reset, and a bus reset leaves it unchanged.
- R6: The reset-request bit is written through bit 1 of address 1 and clears on a bus reset. `long_reset_req` is high exactly while the bit is set and `xfer_busy` is low.
- R7: The gap count loads from a write to address 1 or from a `cfg_gap_vld` pulse. If both arrive in the same cycle, the register write wins.
- R8: A bus reset that follows an earlier bus reset with no gap update since then loads 3Fh into the gap count. A single bus reset after an update keeps the value.
- R9: A bus reset drops `id_valid`. A `selfid_done` pulse loads `selfid_phy_id`, sets `id_valid` and raises `stat_xfer` for exactly one cycle. Both outputs are visible in the cycle after the pulse.
- R10: The cable-power bit reflects `cable_pwr_in` through a two-flop synchronizer, so it changes on the second clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| bus_rst | input | 1 | Bus reset event pulse |
| tree_root | input | 1 | Tree identification chose this node as root |
| selfid_done | input | 1 | Self-ID completed |
| selfid_phy_id | input | 6 | Physical ID assigned by self-ID |
| cfg_gap_vld | input | 1 | Configuration packet carries a gap count |
| cfg_gap | input | 6 | Gap count from the configuration packet |
| cable_pwr_in | input | 1 | Asynchronous cable power good |
| xfer_busy | input | 1 | Receive or transmit in progress |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| id_valid | output | 1 | Physical ID is valid |
| stat_xfer | output | 1 | One-cycle strobe requesting an unsolicited register 0 transfer |
| long_reset_req | output | 1 | Pending long bus reset request, gated by traffic |

## Verification
The bench sweeps every gap value through both load paths. A bank that dropped bits or gave the packet path priority would read back the wrong code.

It runs bus-reset chains in which the reset count and the kind of update in between are varied. A design that reset the gap on a single bus reset, or that ignored packet updates as intervening writes, would show 3Fh at the wrong step.

Root holdoff is checked across bus resets to catch a design that clears it on a bus reset. The reset request is checked with and without traffic to catch a request that fires during a transfer. The ID strobe is sampled in the cycle after self-ID and in the cycle after that, which catches a strobe that lasts two cycles or arrives late.

// File: rtl/phy_base_regs.sv
module phy_base_regs #(
  parameter int unsigned NUM_PORTS   = 3,
  parameter int unsigned DELAY_CODE  = 0,
  parameter logic [5:0]  GAP_DEFAULT = 6'h3F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_rst,
  input  logic       tree_root,
  input  logic       selfid_done,
  input  logic [5:0] selfid_phy_id,
  input  logic       cfg_gap_vld,
  input  logic [5:0] cfg_gap,
  input  logic       cable_pwr_in,
  input  logic       xfer_busy,
  input  logic [2:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       id_valid,
  output logic       stat_xfer,
  output logic       long_reset_req
);

  localparam logic [7:0] CAP_BYTE   = {3'b111, 1'b0, 4'(NUM_PORTS)};
  localparam logic [7:0] SPEED_BYTE = {3'b111, 1'b0, 4'(DELAY_CODE)};

  logic [5:0] phy_id;
  logic       root;
  logic       holdoff;
  logic       rst_req;
  logic [5:0] gap;
  logic       gap_armed;
  logic [1:0] pwr_sync;

  wire ctrl_wr = wr_en && (addr == 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwr_sync <= 2'b00;
    else        pwr_sync <= {pwr_sync[0], cable_pwr_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_id    <= 6'd0;
      id_valid  <= 1'b0;
      root      <= 1'b0;
      holdoff   <= 1'b0;
      rst_req   <= 1'b0;
      gap       <= GAP_DEFAULT;
      gap_armed <= 1'b0;
      stat_xfer <= 1'b0;
    end else begin
      stat_xfer <= selfid_done && !bus_rst;
      if (bus_rst) begin
        root     <= 1'b0;
        rst_req  <= 1'b0;
        id_valid <= 1'b0;
      end else begin
        if (tree_root) root <= 1'b1;
        if (selfid_done) begin
          phy_id   <= selfid_phy_id;
          id_valid <= 1'b1;
        end
        if (ctrl_wr) rst_req <= wdata[6];
      end
      if (ctrl_wr) holdoff <= wdata[7];
      if (ctrl_wr) begin
        gap       <= wdata[5:0];
        gap_armed <= 1'b0;
      end else if (cfg_gap_vld) begin
        gap       <= cfg_gap;
        gap_armed <= 1'b0;
      end else if (bus_rst) begin
        if (gap_armed) gap <= GAP_DEFAULT;
        gap_armed <= 1'b1;
      end
    end
  end

  assign long_reset_req = rst_req && !xfer_busy;

  always_comb begin
    case (addr)
      3'd0:    rdata = {phy_id, root, pwr_sync[1]};
      3'd1:    rdata = {holdoff, rst_req, gap};
      3'd2:    rdata = CAP_BYTE;
      3'd3:    rdata = SPEED_BYTE;
      default: rdata = 8'h00;
    endcase
  end

  // R4
  root_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> (root == 1'b0));

  // R5
  holdoff_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rst && !(wr_en && addr == 3'd1)) |=> $stable(holdoff));

  // R6
  req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !long_reset_req || !rst_req);

  // R9
  id_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst |=> !id_valid);

  // R9
  strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_valid) |-> stat_xfer);

endmodule

// File: tb/sim_phy_base_regs.sv
`timescale 1ns/1ps
module sim_phy_base_regs;
  logic clk = 0;
  always #2 clk = ~clk;

  logic rst_n = 0, bus_rst = 0, tree_root = 0, selfid_done = 0, cfg_gap_vld = 0;
  logic cable_pwr_in = 0, xfer_busy = 0, wr_en = 0;
  logic [5:0] selfid_phy_id = 0, cfg_gap = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic id_valid, stat_xfer, long_reset_req;

  int checks = 0, fails = 0;

  phy_base_regs u0 (.clk, .rst_n, .bus_rst, .tree_root, .selfid_done, .selfid_phy_id,
    .cfg_gap_vld, .cfg_gap, .cable_pwr_in, .xfer_busy, .addr, .wr_en, .wdata,
    .rdata, .id_valid, .stat_xfer, .long_reset_req);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic rd(string req, logic [2:0] a, logic [7:0] exp);
    addr = a; #0.5; chk(req, rdata, exp);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic breset();
    bus_rst = 1; tick(); bus_rst = 0;
  endtask

  task automatic cfg(logic [5:0] g);
    cfg_gap = g; cfg_gap_vld = 1; tick(); cfg_gap_vld = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; tick();
    // R1 and R3: every address after reset
    for (int a = 0; a < 8; a++) begin
      logic [7:0] e;
      case (a) 0: e = 8'h00; 1: e = 8'h3F; 2: e = 8'hE3; 3: e = 8'hE0; default: e = 8'h00; endcase
      rd(a < 2 ? "R1" : "R3", 3'(a), e);
    end
    chk("R1 id_valid", {7'd0, id_valid}, 8'h00);

    // R3: writes to other addresses ignored
    for (int a = 0; a < 8; a++) if (a != 1) wr(3'(a), 8'hFF);
    rd("R3", 3'd0, 8'h00); rd("R3", 3'd1, 8'h3F); rd("R3", 3'd2, 8'hE3); rd("R3", 3'd3, 8'hE0);
    rd("R3", 3'd5, 8'h00);

    // R7 and R2: exhaustive gap via write and via packet
    for (int g = 0; g < 64; g++) begin
      wr(3'd1, 8'(g)); rd("R7 write", 3'd1, 8'(g));
      cfg(6'(63 - g)); rd("R7 cfg", 3'd1, 8'(63 - g));
    end
    // R7: write wins over packet in the same cycle
    cfg_gap = 6'h11; cfg_gap_vld = 1; wr(3'd1, 8'h22); cfg_gap_vld = 0;
    rd("R7 priority", 3'd1, 8'h22);

    // R10: two-edge synchronizer latency
    cable_pwr_in = 1; tick(); rd("R10 first edge", 3'd0, 8'h00);
    tick(); rd("R10 second edge", 3'd0, 8'h01);

    // R8: gap reset rules
    wr(3'd1, 8'h10); breset(); rd("R8 single reset", 3'd1, 8'h10);
    breset(); rd("R8 double reset", 3'd1, 8'h3F);
    wr(3'd1, 8'h05); breset(); cfg(6'h07); breset(); rd("R8 cfg intervenes", 3'd1, 8'h07);
    breset(); rd("R8 after cfg double", 3'd1, 8'h3F);

    // R5 and R6: holdoff and reset request
    wr(3'd1, 8'hC4); rd("R2 R5 R6 layout", 3'd1, 8'hC4);
    chk("R6 req idle", {7'd0, long_reset_req}, 8'h01);
    xfer_busy = 1; #0.5; chk("R6 req gated", {7'd0, long_reset_req}, 8'h00);
    xfer_busy = 0;
    breset(); rd("R5 R6 after bus reset", 3'd1, 8'h84);
    chk("R6 req cleared", {7'd0, long_reset_req}, 8'h00);
    rst_n = 0; tick(); rst_n = 1; tick();
    rd("R5 hw reset clears holdoff", 3'd1, 8'h3F);

    // R4 and R9: root, self-ID, strobe
    tick(); tick();
    tree_root = 1; tick(); tree_root = 0;
    rd("R4 root set", 3'd0, 8'h03);
    selfid_phy_id = 6'h2A; selfid_done = 1; tick(); selfid_done = 0;
    chk("R9 strobe", {6'd0, id_valid, stat_xfer}, 8'h03);
    rd("R2 R9 id loaded", 3'd0, 8'hAB);
    tick(); chk("R9 strobe one cycle", {6'd0, id_valid, stat_xfer}, 8'h02);
    breset(); chk("R9 id invalid", {7'd0, id_valid}, 8'h00);
    rd("R4 root cleared", 3'd0, 8'hA9);
    bus_rst = 1; tree_root = 1; tick(); bus_rst = 0; tree_root = 0;
    rd("R4 reset beats root", 3'd0, 8'hA9);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule